// File: doc/BRIEF.md
# Read-Sequence Command Unlock Detector

This block watches the read cycles a memory controller performs and spots a fixed unlock sequence hidden in their addresses. It needs five consecutive plain reads at five set addresses. A sixth read then names one of four commands:
- commit the working array to the persistent store
- reload the working array from the persistent store
- turn off the automatic commit on power loss
- turn it back on

When that sixth address is one of the four command keys, the block raises a one-cycle command pulse carrying a 2-bit code. Every read in the sequence behaves as an ordinary read towards the rest of the controller. The detector only listens.

The controller gives the block three inputs:
- a single-cycle strobe for each completed read, taken at the active edge of the enable that qualified the read
- the write-enable level
- the full read address

A busy input freezes the matcher while a command is being carried out elsewhere. The data path and the execution of the commands lie outside this block.

Top module: `seqcmd_unlock`

## Requirements
- R1: After reset, `cmd_valid_o` is 0 and the matcher holds no progress, so a lone command key issues nothing.
- R2: Five strobed reads at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order, followed by a strobed read at a command key, set `cmd_valid_o` in the cycle after the sixth strobe. Idle cycles between the strobes are allowed.
- R3: The command code on `cmd_code_o` follows the sixth address: 0x8FC0 gives 0, 0x4C63 gives 1, 0x8B45 gives 2 and 0x4B46 gives 3.
- R4: Only address bits 15..0 are compared. Bit 16 has no effect on matching.
- R5: A strobed read whose address differs from the next expected prefix entry discards all progress, and the rest of the sequence then issues no command.
- R6: A sixth address that is not a command key issues no command and discards progress.
- R7: A strobed read that breaks the sequence with address 0x4E38 counts as the first step of a new sequence. This holds in the prefix and in the sixth position.
- R8: Any cycle with `wr_en_n_i` low while not busy discards all progress. This includes a strobe that arrives with write enable active.
- R9: While `busy_i` is high, strobes and the write-enable level are ignored and progress is held unchanged.
- R10: `cmd_valid_o` lasts exactly one cycle per command, and the matcher returns to no progress after a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_strobe_i | input | 1 | One-cycle pulse marking a completed read cycle |
| wr_en_n_i | input | 1 | Write-enable level, active low (0 = write cycle) |
| busy_i | input | 1 | Command execution in progress; freezes the matcher |
| addr_i | input | 17 | Address of the read cycle |
| cmd_valid_o | output | 1 | One-cycle command pulse |
| cmd_code_o | output | 2 | Command code, meaningful while `cmd_valid_o` is high |

## Verification
Two situations are hard to reach from the ports. One is a sequence broken at a chosen depth by the one address that restarts it. The other is a break by the write level or by a busy window at that same depth. The bench reaches each depth by replaying the prefix up to position k. It then injects the disturbance: a wrong key, 0x4E38, a write cycle, or a busy strobe. After that it completes the sequence. A step-counting reference model in the bench decides whether the final read must pulse, and which code it must carry.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

    localparam int KEY_W      = 16;
    localparam int PREFIX_LEN = 5;
    localparam int NUM_CMDS   = 4;
    localparam int CMD_W      = $clog2(NUM_CMDS);
    localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

    typedef enum logic [CMD_W-1:0] {
        CMD_COMMIT  = 2'd0,
        CMD_RELOAD  = 2'd1,
        CMD_AUTO_OFF = 2'd2,
        CMD_AUTO_ON = 2'd3
    } cmd_e;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              pulse;
        cmd_e              code;
    } seq_state_t;

    // Unlock prefix, in the order it must be read.
    function automatic logic [KEY_W-1:0] prefix_key(input int idx);
        case (idx)
            0:       prefix_key = 16'h4E38;
            1:       prefix_key = 16'hB1C7;
            2:       prefix_key = 16'h83E0;
            3:       prefix_key = 16'h7C1F;
            default: prefix_key = 16'h703F;
        endcase
    endfunction

    // Final-position keys, indexed by command code.
    function automatic logic [KEY_W-1:0] command_key(input int code);
        case (code)
            0:       command_key = 16'h8FC0;
            1:       command_key = 16'h4C63;
            2:       command_key = 16'h8B45;
            default: command_key = 16'h4B46;
        endcase
    endfunction

endpackage

// File: rtl/seqcmd_keymatch.sv
module seqcmd_keymatch
    import seqcmd_pkg::*;
#(
    parameter int N_KEYS = PREFIX_LEN
) (
    input  logic [KEY_W-1:0]  key_i,
    output logic [N_KEYS-1:0] hit_o
);

    for (genvar i = 0; i < N_KEYS; i++) begin : g_cmp
        assign hit_o[i] = (key_i == prefix_key(i));
    end

endmodule

// File: rtl/seqcmd_cmddecode.sv
module seqcmd_cmddecode
    import seqcmd_pkg::*;
#(
    parameter int N_CMDS = NUM_CMDS
) (
    input  logic [KEY_W-1:0] key_i,
    output logic             known_o,
    output cmd_e             code_o
);

    logic [N_CMDS-1:0] hit;

    for (genvar c = 0; c < N_CMDS; c++) begin : g_cmp
        assign hit[c] = (key_i == command_key(c));
    end

    always_comb begin
        known_o = 1'b0;
        code_o  = CMD_COMMIT;
        for (int c = 0; c < N_CMDS; c++) begin
            if (hit[c]) begin
                known_o = 1'b1;
                code_o  = cmd_e'(c[CMD_W-1:0]);
            end
        end
    end

endmodule

// File: rtl/seqcmd_fsm.sv
module seqcmd_fsm
    import seqcmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strobe_i,
    input  logic                  wr_n_i,
    input  logic                  busy_i,
    input  logic [PREFIX_LEN-1:0] pfx_hit_i,
    input  logic                  cmd_known_i,
    input  cmd_e                  cmd_code_i,
    output logic [STEP_W-1:0]     step_o,
    output logic                  pulse_o,
    output cmd_e                  code_o
);

    localparam logic [STEP_W-1:0] TAIL_STEP = STEP_W'(PREFIX_LEN);

    seq_state_t state_q, state_d;
    logic       expected_hit;
    logic       at_tail;
    logic [STEP_W-1:0] restart_step;

    always_comb begin
        expected_hit = 1'b0;
        for (int i = 0; i < PREFIX_LEN; i++) begin
            if (state_q.step == STEP_W'(i)) begin
                expected_hit = pfx_hit_i[i];
            end
        end
        at_tail      = (state_q.step == TAIL_STEP);
        restart_step = pfx_hit_i[0] ? STEP_W'(1) : '0;

        state_d       = state_q;
        state_d.pulse = 1'b0;
        if (!busy_i) begin
            if (!wr_n_i) begin
                state_d.step = '0;
            end else if (strobe_i) begin
                if (at_tail) begin
                    if (cmd_known_i) begin
                        state_d.pulse = 1'b1;
                        state_d.code  = cmd_code_i;
                        state_d.step  = '0;
                    end else begin
                        state_d.step  = restart_step;
                    end
                end else if (expected_hit) begin
                    state_d.step = state_q.step + STEP_W'(1);
                end else begin
                    state_d.step = restart_step;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{step: '0, pulse: 1'b0, code: CMD_COMMIT};
        end else begin
            state_q <= state_d;
        end
    end

    assign step_o  = state_q.step;
    assign pulse_o = state_q.pulse;
    assign code_o  = state_q.code;

endmodule

// File: rtl/seqcmd_unlock.sv
module seqcmd_unlock
    import seqcmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe_i,
    input  logic              wr_en_n_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              cmd_valid_o,
    output logic [CMD_W-1:0]  cmd_code_o
);

    logic [KEY_W-1:0]      key;
    logic [PREFIX_LEN-1:0] pfx_hit;
    logic                  cmd_known;
    cmd_e                  cmd_code;
    cmd_e                  code_q;
    logic [STEP_W-1:0]     step_q;

    assign key = addr_i[KEY_W-1:0];

    if (ADDR_W > KEY_W) begin : g_upper
        logic unused_upper_bits;
        assign unused_upper_bits = ^addr_i[ADDR_W-1:KEY_W];
    end

    seqcmd_keymatch #(.N_KEYS(PREFIX_LEN)) u_keymatch (
        .key_i (key),
        .hit_o (pfx_hit)
    );

    seqcmd_cmddecode #(.N_CMDS(NUM_CMDS)) u_cmddecode (
        .key_i   (key),
        .known_o (cmd_known),
        .code_o  (cmd_code)
    );

    seqcmd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_i    (rd_strobe_i),
        .wr_n_i      (wr_en_n_i),
        .busy_i      (busy_i),
        .pfx_hit_i   (pfx_hit),
        .cmd_known_i (cmd_known),
        .cmd_code_i  (cmd_code),
        .step_o      (step_q),
        .pulse_o     (cmd_valid_o),
        .code_o      (code_q)
    );

    assign cmd_code_o = code_q;

endmodule

// File: rtl/seqcmd_unlock_chk.sv
module seqcmd_unlock_chk
    import seqcmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_strobe_i,
    input logic              wr_en_n_i,
    input logic              busy_i,
    input logic              cmd_valid_o,
    input logic [STEP_W-1:0] step_q
);

    // R10: never two command pulses in adjacent cycles
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    // R2: a pulse follows a non-busy read strobe taken with the full prefix matched
    a_r2_pulse_needs_tail: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> ($past(step_q) == STEP_W'(PREFIX_LEN)
                         && $past(rd_strobe_i) && !$past(busy_i) && $past(wr_en_n_i)));

    // R9: progress frozen while busy
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(step_q));

    // R8: a write cycle clears progress
    a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !wr_en_n_i) |=> (step_q == '0 && !cmd_valid_o));

    // R2: progress never exceeds the prefix length
    a_r2_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= STEP_W'(PREFIX_LEN));

endmodule

bind seqcmd_unlock seqcmd_unlock_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe_i (rd_strobe_i),
    .wr_en_n_i   (wr_en_n_i),
    .busy_i      (busy_i),
    .cmd_valid_o (cmd_valid_o),
    .step_q      (step_q)
);

// File: tb/seqcmd_unlock_test.sv
module seqcmd_unlock_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_strobe = 1'b0;
    logic        wr_n = 1'b1;
    logic        busy = 1'b0;
    logic [16:0] addr = '0;
    logic        valid;
    logic [1:0]  code;

    int n_tests = 0;
    int n_fail  = 0;
    int m_step  = 0;

    seqcmd_unlock uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_strobe_i (rd_strobe),
        .wr_en_n_i   (wr_n),
        .busy_i      (busy),
        .addr_i      (addr),
        .cmd_valid_o (valid),
        .cmd_code_o  (code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] pfx(input int i);
        case (i)
            0: pfx = 16'h4E38;
            1: pfx = 16'hB1C7;
            2: pfx = 16'h83E0;
            3: pfx = 16'h7C1F;
            default: pfx = 16'h703F;
        endcase
    endfunction

    function automatic logic [15:0] ckey(input int c);
        case (c)
            0: ckey = 16'h8FC0;
            1: ckey = 16'h4C63;
            2: ckey = 16'h8B45;
            default: ckey = 16'h4B46;
        endcase
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One strobed read; the reference model decides the expected pulse.
    task automatic rd(input logic [16:0] a, input logic b, input string tag);
        int exp_v = 0;
        int exp_c = 0;
        int found = -1;
        logic [15:0] k = a[15:0];
        @(negedge clk);
        rd_strobe = 1'b1; addr = a; busy = b; wr_n = 1'b1;
        if (!b) begin
            for (int c = 0; c < 4; c++) if (k == ckey(c)) found = c;
            if (m_step == 5) begin
                if (found >= 0) begin
                    exp_v = 1; exp_c = found; m_step = 0;
                end else begin
                    m_step = (k == 16'h4E38) ? 1 : 0;
                end
            end else if (k == pfx(m_step)) begin
                m_step++;
            end else begin
                m_step = (k == 16'h4E38) ? 1 : 0;
            end
        end
        @(negedge clk);
        rd_strobe = 1'b0; busy = 1'b0;
        check(int'(valid), exp_v, tag);
        if (exp_v == 1) begin
            check(int'(code), exp_c, {tag, "/R3"});
            @(negedge clk);
            check(int'(valid), 0, "R10");
        end
    endtask

    // Write-level cycle, optionally with a strobe and/or busy.
    task automatic wr(input logic with_strobe, input logic b, input string tag);
        @(negedge clk);
        wr_n = 1'b0; rd_strobe = with_strobe; busy = b; addr = {1'b0, pfx(m_step < 5 ? m_step : 0)};
        if (!b) m_step = 0;
        @(negedge clk);
        wr_n = 1'b1; rd_strobe = 1'b0; busy = 1'b0;
        check(int'(valid), 0, tag);
    endtask

    task automatic prefix_range(input int from, input int upto, input logic hi, input string tag);
        for (int i = from; i < upto; i++) rd({hi, pfx(i)}, 1'b0, tag);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(int'(valid), 0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(valid), 0, "R1");
        rd({1'b0, ckey(0)}, 1'b0, "R1");

        // R2 / R3: every command, with idle gaps on the second pass
        for (int c = 0; c < 4; c++) begin
            prefix_range(0, 5, 1'b0, "R2");
            rd({1'b0, ckey(c)}, 1'b0, "R2");
        end
        for (int c = 3; c >= 0; c--) begin
            for (int i = 0; i < 5; i++) begin
                rd({1'b0, pfx(i)}, 1'b0, "R2");
                repeat (c) @(negedge clk);
            end
            rd({1'b0, ckey(c)}, 1'b0, "R2");
        end

        // R4: bit 16 set everywhere, and mixed
        for (int c = 0; c < 4; c++) begin
            prefix_range(0, 5, 1'b1, "R4");
            rd({1'b1, ckey(c)}, 1'b0, "R4");
        end
        for (int i = 0; i < 5; i++) rd({1'(i % 2), pfx(i)}, 1'b0, "R4");
        rd({1'b1, ckey(2)}, 1'b0, "R4");

        // R5: wrong key at each prefix depth, then the remainder
        for (int k = 0; k < 5; k++) begin
            prefix_range(0, k, 1'b0, "R5");
            rd({1'b0, pfx(k) ^ 16'h0100}, 1'b0, "R5");
            prefix_range(k, 5, 1'b0, "R5");
            rd({1'b0, ckey(0)}, 1'b0, "R5");
        end

        // R7: break with the first key at each depth, including the sixth
        for (int k = 1; k <= 5; k++) begin
            prefix_range(0, k, 1'b0, "R7");
            rd({1'b0, 16'h4E38}, 1'b0, "R7");
            prefix_range(1, 5, 1'b0, "R7");
            rd({1'b0, ckey(1)}, 1'b0, "R7");
        end

        // R6: unknown sixth address, then a bare command key, then a full run
        prefix_range(0, 5, 1'b0, "R6");
        rd({1'b0, 16'h1234}, 1'b0, "R6");
        rd({1'b0, ckey(0)}, 1'b0, "R6");
        prefix_range(0, 5, 1'b0, "R6");
        rd({1'b0, 16'h8FC1}, 1'b0, "R6");
        rd({1'b0, ckey(3)}, 1'b0, "R6");
        prefix_range(0, 5, 1'b0, "R6");
        rd({1'b0, ckey(3)}, 1'b0, "R6");

        // R8: write cycles (plain and strobed) at each depth
        for (int k = 0; k <= 5; k++) begin
            prefix_range(0, k, 1'b0, "R8");
            wr(k % 2 == 1, 1'b0, "R8");
            prefix_range(k, 5, 1'b0, "R8");
            rd({1'b0, ckey(2)}, 1'b0, "R8");
        end

        // R9: busy strobes and busy writes leave progress untouched
        for (int k = 0; k <= 5; k++) begin
            prefix_range(0, k, 1'b0, "R9");
            rd({1'b0, 16'hDEAD}, 1'b1, "R9");
            wr(1'b1, 1'b1, "R9");
            rd({1'b0, ckey(0)}, 1'b1, "R9");
            prefix_range(k, 5, 1'b0, "R9");
            rd({1'b0, ckey(k % 4)}, 1'b0, "R9");
        end

        // R10: back-to-back sequences, one pulse each
        for (int r = 0; r < 3; r++) begin
            prefix_range(0, 5, 1'b0, "R10");
            rd({1'b0, ckey(r)}, 1'b0, "R10");
        end
        rd({1'b0, ckey(1)}, 1'b0, "R10");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule